// File: doc/BRIEF.md
# Double-Buffered One-Shot DMA Channel

This block is a bus-mastering DMA engine for one peripheral channel. It takes a byte stream from a peripheral through a valid/ready handshake and writes each byte to memory through a single-beat write request interface. Each channel has two descriptor sets, and each set holds a buffer address, a byte count and a command word. Hardware drains one set, the active set. Software meanwhile programs the other, idle set. When the active set's byte count runs out, the engine marks that set done and moves straight to the other set if software has armed it. A one-shot transfer can therefore be re-armed without stopping the channel.

Several channels share one register address map. The parameter `CHAN_IDX` places this channel's descriptor window and control register in that map. Each channel instance has its own memory write port. Arbitration among channels and the peripheral protocols sit outside this block.

Top module: `pingpong_dma_chan`

## Requirements
- R1: Register map for channel k. Descriptor set 0 is at 0x1000 + 0x20*k and set 1 is 0x10 above it. In each set the buffer address is at +0x0, the byte count (LEN_W bits) at +0x4 and the command at +0x8. The control register is at 0xC00 + 0x10*k. A read returns data on reg_rdata one clock after reg_rd is sampled. Reads of addresses this channel does not own return 0.
- R2: Writing 1 to command bit 0 arms the set, and bit 0 reads back the armed state. The engine starts only a set that is armed and has a nonzero byte count. An armed set with a zero byte count stays armed and does not start.
- R3: Each byte accepted on the peripheral stream produces exactly one memory write request. Its address is the set's buffer address plus the number of bytes already taken from that set. Only one request is outstanding at a time. A request holds its address and data until mw_ack. pd_ready is low while a request is pending or the channel is idle.
- R4: The set completes when the acknowledge of its last byte arrives. Its armed bit then clears, and its done flag sets: control bit 0 for set 0, bit 1 for set 1.
- R5: At completion, if the other set is armed with a nonzero count, the active-set pointer (control bit 4) flips and streaming continues from that set's address. The channel does not go idle in between.
- R6: At completion, if the other set is not eligible, the channel goes idle: control bit 5 (busy) is 0 and the active-set pointer keeps its value.
- R7: An idle channel starts the set under the pointer if that set is eligible. Otherwise it starts the other set if that one is eligible, and the pointer flips to it.
- R8: While the channel is busy, writes to the address, count and command of the active set are ignored. The idle set stays writable.
- R9: Writing 1 to a done bit of the control register clears it, and writing 0 leaves it unchanged. A completion in the same cycle as a clear leaves the flag set.
- R10: After reset all descriptors, armed bits and done flags are 0, the pointer is 0, the channel is idle, mw_req is low and pd_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of a 32-bit register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, 0 when not addressed |
| pd_valid | input | 1 | Peripheral byte available |
| pd_data | input | 8 | Peripheral byte |
| pd_ready | output | 1 | Channel takes the byte this cycle |
| mw_req | output | 1 | Memory write request pending |
| mw_addr | output | MA_W | Memory byte address |
| mw_data | output | 8 | Memory write byte |
| mw_ack | input | 1 | Memory accepted the pending request |

## Verification
A corrupted active-set pointer or byte counter shows up first on mw_addr. The next request after a flip, or after a wrong count, lands at an address the reference model did not predict. That happens within the two cycles each byte takes. A wrong armed or done bit only shows up when software reads the command or control register. It can also show up a whole buffer later, as a missed or spurious flip. The bench therefore compares the memory port and the read data against its model on every clock, and reads the control register back after each buffer boundary.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int DESC_BASE   = 'h1000;
  localparam int DESC_STRIDE = 'h20;
  localparam int SET_STRIDE  = 'h10;
  localparam int CTL_BASE    = 'hC00;
  localparam int CTL_STRIDE  = 'h10;

  localparam int FLD_ADDR = 'h0;
  localparam int FLD_LEN  = 'h4;
  localparam int FLD_CMD  = 'h8;

  localparam int CTL_PTR_BIT  = 4;
  localparam int CTL_BUSY_BIT = 5;

  localparam int NUM_SETS = 2;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;
endpackage

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
#(
  parameter int CHAN_IDX = 0,
  parameter int ADDR_W   = 13,
  parameter int MA_W     = 32,
  parameter int LEN_W    = 16,
  parameter int DW       = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_wr,
  input  logic                           reg_rd,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DW-1:0]                  reg_wdata,
  output logic [DW-1:0]                  reg_rdata,
  input  logic                           eng_busy,
  input  logic                           eng_ptr,
  input  logic                           cmpl,
  input  logic                           cmpl_set,
  output logic [NUM_SETS-1:0][MA_W-1:0]  set_addr,
  output logic [NUM_SETS-1:0][LEN_W-1:0] set_len,
  output logic [NUM_SETS-1:0]            set_arm,
  output logic [NUM_SETS-1:0]            done_flags
);
  localparam int CTL_OFF  = CTL_BASE + CTL_STRIDE * CHAN_IDX;
  localparam int DESC_OFF = DESC_BASE + DESC_STRIDE * CHAN_IDX;

  logic              ctl_hit;
  logic [DW-1:0]     ctl_view;
  logic [NUM_SETS-1:0][DW-1:0] set_view;
  logic [NUM_SETS-1:0]         set_sel;

  assign ctl_hit = (reg_addr == ADDR_W'(CTL_OFF));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    localparam int SBASE = DESC_OFF + SET_STRIDE * s;
    logic hit_a, hit_l, hit_c, locked, mine_done;

    assign hit_a     = (reg_addr == ADDR_W'(SBASE + FLD_ADDR));
    assign hit_l     = (reg_addr == ADDR_W'(SBASE + FLD_LEN));
    assign hit_c     = (reg_addr == ADDR_W'(SBASE + FLD_CMD));
    assign locked    = eng_busy && (eng_ptr == 1'(s));
    assign mine_done = cmpl && (cmpl_set == 1'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        set_addr[s]   <= '0;
        set_len[s]    <= '0;
        set_arm[s]    <= 1'b0;
        done_flags[s] <= 1'b0;
      end else begin
        if (reg_wr && !locked) begin
          if (hit_a) set_addr[s] <= reg_wdata[MA_W-1:0];
          if (hit_l) set_len[s]  <= reg_wdata[LEN_W-1:0];
          if (hit_c) set_arm[s]  <= reg_wdata[0];
        end
        if (reg_wr && ctl_hit && reg_wdata[s]) done_flags[s] <= 1'b0;
        if (mine_done) begin
          set_arm[s]    <= 1'b0;
          done_flags[s] <= 1'b1;
        end
      end
    end

    always_comb begin
      set_sel[s]  = hit_a | hit_l | hit_c;
      set_view[s] = '0;
      if (hit_a) set_view[s] = DW'(set_addr[s]);
      if (hit_l) set_view[s] = DW'(set_len[s]);
      if (hit_c) set_view[s] = DW'(set_arm[s]);
    end
  end

  always_comb begin
    ctl_view = '0;
    ctl_view[NUM_SETS-1:0] = done_flags;
    ctl_view[CTL_PTR_BIT]  = eng_ptr;
    ctl_view[CTL_BUSY_BIT] = eng_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (reg_rd) begin
        if (ctl_hit) reg_rdata <= ctl_view;
        for (int s = 0; s < NUM_SETS; s++)
          if (set_sel[s]) reg_rdata <= set_view[s];
      end
    end
  end
endmodule

// File: rtl/pp_dma_xfer.sv
module pp_dma_xfer
  import pp_dma_pkg::*;
#(
  parameter int MA_W  = 32,
  parameter int LEN_W = 16,
  parameter int PD_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SETS-1:0][MA_W-1:0]  set_addr,
  input  logic [NUM_SETS-1:0][LEN_W-1:0] set_len,
  input  logic [NUM_SETS-1:0]            set_arm,
  input  logic                           pd_valid,
  input  logic [PD_W-1:0]                pd_data,
  output logic                           pd_ready,
  output logic                           mw_req,
  output logic [MA_W-1:0]                mw_addr,
  output logic [PD_W-1:0]                mw_data,
  input  logic                           mw_ack,
  output logic                           eng_busy,
  output logic                           eng_ptr,
  output logic                           cmpl,
  output logic                           cmpl_set
);
  eng_state_e        state;
  logic [MA_W-1:0]   cur_addr;
  logic [LEN_W-1:0]  remain;
  logic              elig_cur, elig_oth, accept;

  assign elig_cur = set_arm[eng_ptr]  && (set_len[eng_ptr]  != '0);
  assign elig_oth = set_arm[!eng_ptr] && (set_len[!eng_ptr] != '0);

  assign eng_busy = (state == ENG_RUN);
  assign pd_ready = eng_busy && !mw_req;
  assign accept   = pd_ready && pd_valid;
  assign cmpl     = eng_busy && mw_req && mw_ack && (remain == '0);
  assign cmpl_set = eng_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      eng_ptr  <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      mw_req   <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (elig_cur) begin
            state    <= ENG_RUN;
            cur_addr <= set_addr[eng_ptr];
            remain   <= set_len[eng_ptr];
          end else if (elig_oth) begin
            state    <= ENG_RUN;
            eng_ptr  <= !eng_ptr;
            cur_addr <= set_addr[!eng_ptr];
            remain   <= set_len[!eng_ptr];
          end
        end
        ENG_RUN: begin
          if (mw_req) begin
            if (mw_ack) begin
              mw_req <= 1'b0;
              if (remain == '0) begin
                if (elig_oth) begin
                  eng_ptr  <= !eng_ptr;
                  cur_addr <= set_addr[!eng_ptr];
                  remain   <= set_len[!eng_ptr];
                end else begin
                  state <= ENG_IDLE;
                end
              end
            end
          end else if (accept) begin
            mw_req   <= 1'b1;
            mw_addr  <= cur_addr;
            mw_data  <= pd_data;
            cur_addr <= cur_addr + 1'b1;
            remain   <= remain - 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pingpong_dma_chan.sv
module pingpong_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int CHAN_IDX = 0,
  parameter int ADDR_W   = 13,
  parameter int MA_W     = 32,
  parameter int LEN_W    = 16,
  parameter int PD_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pd_valid,
  input  logic [PD_W-1:0]   pd_data,
  output logic              pd_ready,
  output logic              mw_req,
  output logic [MA_W-1:0]   mw_addr,
  output logic [PD_W-1:0]   mw_data,
  input  logic              mw_ack
);
  logic [NUM_SETS-1:0][MA_W-1:0]  set_addr;
  logic [NUM_SETS-1:0][LEN_W-1:0] set_len;
  logic [NUM_SETS-1:0]            set_arm;
  logic [NUM_SETS-1:0]            done_flags;
  logic eng_busy, eng_ptr, cmpl, cmpl_set;

  pp_dma_regs #(
    .CHAN_IDX(CHAN_IDX), .ADDR_W(ADDR_W), .MA_W(MA_W), .LEN_W(LEN_W), .DW(32)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(eng_busy), .eng_ptr(eng_ptr), .cmpl(cmpl), .cmpl_set(cmpl_set),
    .set_addr(set_addr), .set_len(set_len), .set_arm(set_arm),
    .done_flags(done_flags)
  );

  pp_dma_xfer #(
    .MA_W(MA_W), .LEN_W(LEN_W), .PD_W(PD_W)
  ) u_xfer (
    .clk(clk), .rst(rst), .set_addr(set_addr), .set_len(set_len),
    .set_arm(set_arm), .pd_valid(pd_valid), .pd_data(pd_data),
    .pd_ready(pd_ready), .mw_req(mw_req), .mw_addr(mw_addr),
    .mw_data(mw_data), .mw_ack(mw_ack), .eng_busy(eng_busy),
    .eng_ptr(eng_ptr), .cmpl(cmpl), .cmpl_set(cmpl_set)
  );
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk #(
  parameter int MA_W = 32,
  parameter int PD_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            pd_ready,
  input logic            mw_req,
  input logic            mw_ack,
  input logic [MA_W-1:0] mw_addr,
  input logic [PD_W-1:0] mw_data,
  input logic            eng_busy,
  input logic            eng_ptr,
  input logic            cmpl,
  input logic            cmpl_set,
  input logic [1:0]      set_arm,
  input logic [1:0]      done_flags
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mw_req && !mw_ack |=> mw_req && $stable(mw_addr) && $stable(mw_data));

  // R3
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    pd_ready |-> !mw_req && eng_busy);

  // R4
  done_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
    cmpl && !cmpl_set |=> done_flags[0] && !set_arm[0]);

  // R4
  done_on_finish1_chk: assert property (@(posedge clk) disable iff (rst)
    cmpl && cmpl_set |=> done_flags[1] && !set_arm[1]);

  // R6
  ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(eng_ptr) |-> $past(cmpl) || !$past(eng_busy));
endmodule

bind pingpong_dma_chan pp_dma_chk #(.MA_W(MA_W), .PD_W(PD_W)) u_chk (
  .clk(clk), .rst(rst), .pd_ready(pd_ready), .mw_req(mw_req),
  .mw_ack(mw_ack), .mw_addr(mw_addr), .mw_data(mw_data),
  .eng_busy(eng_busy), .eng_ptr(eng_ptr), .cmpl(cmpl), .cmpl_set(cmpl_set),
  .set_arm(set_arm), .done_flags(done_flags)
);

// File: tb/pingpong_dma_chan_test.sv
module pingpong_dma_chan_test;
  localparam int CH = 2;
  localparam int CTL = 'hC00 + 'h10 * CH;
  localparam int S0 = 'h1000 + 'h20 * CH;
  localparam int S1 = S0 + 'h10;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic pd_valid = 0, pd_ready, mw_req, mw_ack = 0;
  logic [7:0] pd_data = '0, mw_data;
  logic [31:0] mw_addr;

  int n_chk = 0, n_fail = 0, n_wr = 0, cyc = 0;
  bit pv_en = 0, ack_en = 0;
  logic [7:0] src_byte = 8'h00;

  // reference model state
  logic [31:0] m_addr[2];
  logic [15:0] m_len[2];
  bit m_arm[2], m_done[2];
  bit m_ptr, m_run, m_req;
  logic [31:0] m_cur, m_maddr, m_rdata;
  int m_rem;
  logic [7:0] m_mdata;

  always #4 clk = ~clk;

  pingpong_dma_chan #(.CHAN_IDX(CH)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pd_valid(pd_valid), .pd_data(pd_data), .pd_ready(pd_ready),
    .mw_req(mw_req), .mw_addr(mw_addr), .mw_data(mw_data), .mw_ack(mw_ack)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    if (a == CTL) return {26'b0, m_run, m_ptr, 2'b00, m_done[1], m_done[0]};
    for (int s = 0; s < 2; s++) begin
      if (a == S0 + 16 * s)     return m_addr[s];
      if (a == S0 + 16 * s + 4) return {16'b0, m_len[s]};
      if (a == S0 + 16 * s + 8) return {31'b0, m_arm[s]};
    end
    return 32'h0;
  endfunction

  function automatic bit m_elig(input bit s);
    return m_arm[s] && (m_len[s] != 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        m_addr[s] <= '0; m_len[s] <= '0; m_arm[s] <= 0; m_done[s] <= 0;
      end
      m_ptr <= 0; m_run <= 0; m_req <= 0; m_cur <= '0; m_rem <= 0;
      m_maddr <= '0; m_mdata <= '0; m_rdata <= '0;
    end else begin
      m_rdata <= reg_rd ? m_read(int'(reg_addr)) : 32'h0;
      for (int s = 0; s < 2; s++) begin
        if (reg_wr && !(m_run && m_ptr == s[0])) begin
          if (int'(reg_addr) == S0 + 16 * s)     m_addr[s] <= reg_wdata;
          if (int'(reg_addr) == S0 + 16 * s + 4) m_len[s]  <= reg_wdata[15:0];
          if (int'(reg_addr) == S0 + 16 * s + 8) m_arm[s]  <= reg_wdata[0];
        end
        if (reg_wr && int'(reg_addr) == CTL && reg_wdata[s]) m_done[s] <= 0;
      end
      if (!m_run) begin
        if (m_elig(m_ptr)) begin
          m_run <= 1; m_cur <= m_addr[m_ptr]; m_rem <= int'(m_len[m_ptr]);
        end else if (m_elig(!m_ptr)) begin
          m_run <= 1; m_ptr <= !m_ptr;
          m_cur <= m_addr[!m_ptr]; m_rem <= int'(m_len[!m_ptr]);
        end
      end else if (m_req) begin
        if (mw_ack) begin
          m_req <= 0;
          if (m_rem == 0) begin
            m_done[m_ptr] <= 1; m_arm[m_ptr] <= 0;
            if (m_elig(!m_ptr)) begin
              m_ptr <= !m_ptr; m_cur <= m_addr[!m_ptr];
              m_rem <= int'(m_len[!m_ptr]);
            end else m_run <= 0;
          end
        end
      end else if (pd_valid) begin
        m_req <= 1; m_maddr <= m_cur; m_mdata <= pd_data;
        m_cur <= m_cur + 1; m_rem <= m_rem - 1;
        src_byte <= src_byte + 8'h11;
      end
      if (mw_req && mw_ack) n_wr++;
    end
  end

  // compare every cycle, then drive stream inputs
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(pd_ready == (m_run && !m_req), "R3 pd_ready", 32'(pd_ready), 32'(m_run && !m_req));
      chk(mw_req == m_req, "R3 R5 mw_req", 32'(mw_req), 32'(m_req));
      if (m_req) begin
        chk(mw_addr == m_maddr, "R3 R5 mw_addr", mw_addr, m_maddr);
        chk(mw_data == m_mdata, "R3 mw_data", 32'(mw_data), 32'(m_mdata));
      end
      chk(reg_rdata == m_rdata, "R1 reg_rdata", reg_rdata, m_rdata);
    end
    pd_data  <= src_byte;
    pd_valid <= pv_en && ($urandom_range(0, 3) != 0);
    mw_ack   <= ack_en && mw_req && ($urandom_range(0, 2) != 0);
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = 13'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = 13'(a);
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4000 && m_run; i++) @(negedge clk);
    chk(!m_run, "R6 idle reached", 32'(m_run), 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", 32'(cyc), 32'h0);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    // R10 reset state
    rd(CTL, d);  chk(d == 32'h0, "R10 ctl after reset", d, 32'h0);
    rd(S0 + 8, d); chk(d == 32'h0, "R10 cmd0 after reset", d, 32'h0);
    chk(pd_ready == 0, "R10 pd_ready low", 32'(pd_ready), 32'h0);

    // R1 map
    wr(S0, 32'h1000_0040); wr(S0 + 4, 32'd5);
    wr(S1, 32'h2000_0000);
    rd(S0, d);     chk(d == 32'h1000_0040, "R1 set0 addr", d, 32'h1000_0040);
    rd(S0 + 4, d); chk(d == 32'd5, "R1 set0 len", d, 32'd5);
    rd(S1, d);     chk(d == 32'h2000_0000, "R1 set1 addr", d, 32'h2000_0000);
    rd('h1000, d); chk(d == 32'h0, "R1 foreign address reads 0", d, 32'h0);

    // R2 zero-length armed set does not start
    wr(S1 + 4, 32'd0); wr(S1 + 8, 32'd1);
    repeat (3) @(negedge clk);
    rd(CTL, d);    chk(d == 32'h0, "R2 zero length not started", d, 32'h0);
    rd(S1 + 8, d); chk(d == 32'h1, "R2 armed readback", d, 32'h1);

    // R7 idle channel picks the other set and flips pointer
    wr(S1 + 4, 32'd3);
    repeat (2) @(negedge clk);
    rd(CTL, d);    chk(d == 32'h30, "R7 start on other set", d, 32'h30);

    // R8 running set locked, idle set writable
    wr(S1 + 4, 32'd7);
    rd(S1 + 4, d); chk(d == 32'd3, "R8 running len write ignored", d, 32'd3);
    wr(S0 + 8, 32'd1);
    rd(S0 + 8, d); chk(d == 32'h1, "R8 idle set armed", d, 32'h1);

    // stream both sets back to back
    pv_en = 1; ack_en = 1;
    wait_idle();
    chk(n_wr == 8, "R3 write count", 32'(n_wr), 32'd8);
    rd(CTL, d);    chk(d == 32'h03, "R4 R5 both done, ptr on set0", d, 32'h03);
    rd(S0 + 8, d); chk(d == 32'h0, "R4 set0 disarmed", d, 32'h0);
    rd(S1 + 8, d); chk(d == 32'h0, "R4 set1 disarmed", d, 32'h0);

    // R9 write-one-to-clear
    wr(CTL, 32'h0);  rd(CTL, d); chk(d == 32'h03, "R9 zero write no effect", d, 32'h03);
    wr(CTL, 32'h1);  rd(CTL, d); chk(d == 32'h02, "R9 clear done0", d, 32'h02);
    wr(CTL, 32'h2);  rd(CTL, d); chk(d == 32'h00, "R9 clear done1", d, 32'h00);

    // R6 single set, channel idles holding pointer at set1
    wr(S1, 32'h3000_00FE); wr(S1 + 4, 32'd4); wr(S1 + 8, 32'd1);
    wait_idle();
    repeat (5) @(negedge clk);
    rd(CTL, d);    chk(d == 32'h12, "R6 idle with pointer held", d, 32'h12);
    chk(n_wr == 12, "R3 write count second run", 32'(n_wr), 32'd12);

    // R5 flip while streaming with re-arm of the idle set mid run
    wr(CTL, 32'h3);
    wr(S1, 32'h4000_0000); wr(S1 + 4, 32'd20); wr(S1 + 8, 32'd1);
    wr(S0, 32'h5000_0000); wr(S0 + 4, 32'd2);  wr(S0 + 8, 32'd1);
    wait_idle();
    rd(CTL, d);    chk(d == 32'h03, "R5 flipped to set0 and finished", d, 32'h03);
    chk(n_wr == 34, "R3 write count third run", 32'(n_wr), 32'd34);

    pv_en = 0; ack_en = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule